// File: doc/BRIEF.md
# Address Quadrant Context Selector

This block is the front end of an address translator. For each request it takes a 64-bit effective address, the access type, a hypervisor-mode flag, a relocation-enable flag and the current partition-ID and process-ID register values. From the two most significant address bits (the quadrant) and the privilege mode it picks the partition and process context that qualify the translation, or it reports a segment fault for a quadrant that a guest may not use.

When a hypervisor access runs with relocation off, no context is needed: the block forms the real address itself. It clears the top four address bits and ORs in an offset register when address bit 63 is clear, and it grants full read, write and execute rights. Results are registered and appear one cycle after a request, marked by a valid strobe and exactly one of three outcome flags. Page-table walking, permission checks and interrupt delivery belong to later stages.

Top module: `qsel`

## Requirements
- R1: After reset, resp_valid, ok, segfault and realmode are 0 and fault_addr is 0.
- R2: A req_valid pulse in one cycle gives resp_valid in the next cycle with exactly one of ok, segfault, realmode set. Without a request in the previous cycle, resp_valid and all three flags are 0.
- R3: With hv=1 and relocation on, quadrant ea[63:62]=0 yields ok with lpid_out=0 and pid_out=pid_reg, and quadrant 1 yields ok with lpid_out=lpid_reg and pid_out=pid_reg.
- R4: With hv=1 and relocation on, quadrant 2 yields ok with lpid_out=lpid_reg and pid_out=0, and quadrant 3 yields ok with lpid_out=0 and pid_out=0.
- R5: With hv=0, quadrant 0 yields ok with lpid_out=lpid_reg and pid_out=pid_reg, and quadrant 3 yields ok with lpid_out=lpid_reg and pid_out=0.
- R6: With hv=0, quadrants 1 and 2 yield segfault; lpid_out and pid_out keep their previous values.
- R7: On a segfault, access type 2'b10 (instruction fetch) sets seg_inst=1 and leaves fault_addr unchanged; access types 2'b00 (load), 2'b01 (store) and 2'b11 (treated as load) set seg_inst=0 and capture the effective address into fault_addr.
- R8: With hv=1 and relocation off, the response is realmode with raddr equal to ea with bits 63:60 cleared (ORed with the offset per R9) and prot_rwx=3'b111 (bit 2 read, bit 1 write, bit 0 execute).
- R9: In the real-mode path, offset_reg is ORed into raddr only when ea[63] is 0; when ea[63] is 1, raddr is ea with bits 63:60 cleared.
- R10: With hv=0 and relocation off, context selection follows R5 and R6 and no realmode response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| ea | input | 64 | Effective address |
| acc_type | input | 2 | 00 load, 01 store, 10 fetch, 11 load |
| hv | input | 1 | Hypervisor mode |
| reloc | input | 1 | Relocation enabled |
| lpid_reg | input | LPID_W | Current partition-ID register |
| pid_reg | input | PID_W | Current process-ID register |
| offset_reg | input | 64 | Real-mode offset register |
| resp_valid | output | 1 | Response strobe |
| ok | output | 1 | Context selected |
| segfault | output | 1 | Illegal quadrant |
| realmode | output | 1 | Real address produced |
| lpid_out | output | LPID_W | Selected partition ID |
| pid_out | output | PID_W | Selected process ID |
| raddr | output | 64 | Real address (real-mode path) |
| prot_rwx | output | 3 | Granted rights on real-mode path |
| seg_inst | output | 1 | Segment fault kind: 1 fetch, 0 data |
| fault_addr | output | 64 | Captured data fault address |

## Verification
The hardest case to reach is the interplay of held state: a fetch fault must leave fault_addr at the address of an earlier data fault, and a fault must leave the context outputs from an earlier good response. The stimulus therefore places data faults, fetch faults and good requests back to back, and mixes idle gaps and random quadrants, modes and offsets so that both polarities of ea[63] meet nonzero offsets in real mode.

// File: rtl/qsel.sv
module qsel #(
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [63:0]       ea,
  input  logic [1:0]        acc_type,
  input  logic              hv,
  input  logic              reloc,
  input  logic [LPID_W-1:0] lpid_reg,
  input  logic [PID_W-1:0]  pid_reg,
  input  logic [63:0]       offset_reg,
  output logic              resp_valid,
  output logic              ok,
  output logic              segfault,
  output logic              realmode,
  output logic [LPID_W-1:0] lpid_out,
  output logic [PID_W-1:0]  pid_out,
  output logic [63:0]       raddr,
  output logic [2:0]        prot_rwx,
  output logic              seg_inst,
  output logic [63:0]       fault_addr
);
  localparam logic [63:0] TOP_CLR = {4'h0, {60{1'b1}}};

  logic [1:0]        quad;
  logic              rm_path, bad_quad, is_fetch;
  logic [LPID_W-1:0] sel_lpid;
  logic [PID_W-1:0]  sel_pid;
  logic [63:0]       rm_addr;

  assign quad     = ea[63:62];
  assign rm_path  = hv & ~reloc;
  assign bad_quad = ~hv & (quad == 2'd1 || quad == 2'd2);
  assign is_fetch = (acc_type == 2'b10);
  assign rm_addr  = (ea & TOP_CLR) | (ea[63] ? 64'd0 : offset_reg);

  always_comb begin
    sel_lpid = '0;
    sel_pid  = '0;
    if (hv) begin
      case (quad)
        2'd0: sel_pid = pid_reg;
        2'd1: begin sel_lpid = lpid_reg; sel_pid = pid_reg; end
        2'd2: sel_lpid = lpid_reg;
        default: ;
      endcase
    end else begin
      sel_lpid = lpid_reg;
      if (quad == 2'd0) sel_pid = pid_reg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      ok         <= 1'b0;
      segfault   <= 1'b0;
      realmode   <= 1'b0;
      lpid_out   <= '0;
      pid_out    <= '0;
      raddr      <= '0;
      prot_rwx   <= '0;
      seg_inst   <= 1'b0;
      fault_addr <= '0;
    end else begin
      resp_valid <= req_valid;
      ok         <= 1'b0;
      segfault   <= 1'b0;
      realmode   <= 1'b0;
      if (req_valid) begin
        if (rm_path) begin
          realmode <= 1'b1;
          raddr    <= rm_addr;
          prot_rwx <= 3'b111;
        end else if (bad_quad) begin
          segfault <= 1'b1;
          seg_inst <= is_fetch;
          if (!is_fetch) fault_addr <= ea;
        end else begin
          ok       <= 1'b1;
          lpid_out <= sel_lpid;
          pid_out  <= sel_pid;
        end
      end
    end
  end
endmodule

module qsel_chk #(
  parameter int LPID_W = 12,
  parameter int PID_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [63:0]       ea,
  input logic [1:0]        acc_type,
  input logic              hv,
  input logic              reloc,
  input logic              resp_valid,
  input logic              ok,
  input logic              segfault,
  input logic              realmode,
  input logic [LPID_W-1:0] lpid_out,
  input logic [PID_W-1:0]  pid_out,
  input logic [2:0]        prot_rwx,
  input logic              seg_inst,
  input logic [63:0]       fault_addr
);
  // R2
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $countones({ok, segfault, realmode}) == 1);
  // R2
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid && !ok && !segfault && !realmode);
  // R6
  guest_bad_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !hv && (ea[63:62] == 2'd1 || ea[63:62] == 2'd2) |=> segfault);
  // R6
  fault_holds_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    segfault |-> $stable(lpid_out) && $stable(pid_out));
  // R7
  data_fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !hv && ea[63:62] == 2'd1 && acc_type != 2'b10 |=> fault_addr == $past(ea) && !seg_inst);
  // R7
  fetch_fault_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    segfault && seg_inst |-> $stable(fault_addr));
  // R8
  rm_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    realmode |-> prot_rwx == 3'b111);
  // R10
  guest_no_rm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !hv |=> !realmode);
endmodule

bind qsel qsel_chk #(.LPID_W(LPID_W), .PID_W(PID_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ea(ea), .acc_type(acc_type),
  .hv(hv), .reloc(reloc), .resp_valid(resp_valid), .ok(ok), .segfault(segfault),
  .realmode(realmode), .lpid_out(lpid_out), .pid_out(pid_out), .prot_rwx(prot_rwx),
  .seg_inst(seg_inst), .fault_addr(fault_addr)
);

// File: tb/qsel_tb.sv
module qsel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 12;
  localparam int PW = 20;

  logic clk = 0, rst_n = 0, req_valid = 0, hv = 0, reloc = 0;
  logic [63:0] ea = 0, offset_reg = 0;
  logic [1:0] acc_type = 0;
  logic [LW-1:0] lpid_reg = 0;
  logic [PW-1:0] pid_reg = 0;
  logic resp_valid, ok, segfault, realmode, seg_inst;
  logic [LW-1:0] lpid_out;
  logic [PW-1:0] pid_out;
  logic [63:0] raddr, fault_addr;
  logic [2:0] prot_rwx;

  qsel #(.LPID_W(LW), .PID_W(PW)) dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  // expected state
  logic e_v, e_ok, e_seg, e_rm, e_inst;
  logic [LW-1:0] e_lpid;
  logic [PW-1:0] e_pid;
  logic [63:0] e_raddr, e_faddr;
  logic [2:0] e_prot;
  string ctx_tag, rm_tag;

  task automatic chk(input bit good, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(resp_valid == e_v, "R2", 64'(resp_valid), 64'(e_v));
    chk({ok, segfault, realmode} == {e_ok, e_seg, e_rm}, "R2",
        64'({ok, segfault, realmode}), 64'({e_ok, e_seg, e_rm}));
    chk(lpid_out == e_lpid, ctx_tag, 64'(lpid_out), 64'(e_lpid));
    chk(pid_out == e_pid, ctx_tag, 64'(pid_out), 64'(e_pid));
    chk(seg_inst == e_inst, "R7", 64'(seg_inst), 64'(e_inst));
    chk(fault_addr == e_faddr, "R7", fault_addr, e_faddr);
    chk(raddr == e_raddr, rm_tag, raddr, e_raddr);
    chk(prot_rwx == e_prot, "R8", 64'(prot_rwx), 64'(e_prot));
  endtask

  // model update for the request applied now
  task automatic model(input bit rv);
    int q;
    e_v = rv; e_ok = 0; e_seg = 0; e_rm = 0;
    if (!rv) return;
    q = int'(ea[63:62]);
    if (hv && !reloc) begin
      e_rm = 1; e_prot = 3'b111;
      e_raddr = {4'h0, ea[59:0]};
      if (ea[63] == 1'b0) e_raddr = e_raddr | offset_reg;
      rm_tag = ea[63] ? "R8" : "R9";
    end else if (!hv && (q == 1 || q == 2)) begin
      e_seg = 1; ctx_tag = "R6";
      e_inst = (acc_type == 2'b10);
      if (!e_inst) e_faddr = ea;
    end else begin
      e_ok = 1;
      if (hv) begin
        ctx_tag = (q < 2) ? "R3" : "R4";
        e_lpid = (q == 1 || q == 2) ? lpid_reg : '0;
        e_pid  = (q < 2) ? pid_reg : '0;
      end else begin
        ctx_tag = reloc ? "R5" : "R10";
        e_lpid = lpid_reg;
        e_pid  = (q == 0) ? pid_reg : '0;
      end
    end
  endtask

  task automatic step(input bit rv, input logic [63:0] a, input logic [1:0] at,
                      input bit h, input bit r);
    req_valid = rv; ea = a; acc_type = at; hv = h; reloc = r;
    model(rv);
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    e_v = 0; e_ok = 0; e_seg = 0; e_rm = 0; e_inst = 0;
    e_lpid = 0; e_pid = 0; e_raddr = 0; e_faddr = 0; e_prot = 0;
    ctx_tag = "R1"; rm_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({resp_valid, ok, segfault, realmode} == 4'b0, "R1", 64'({resp_valid, ok, segfault, realmode}), 0);
    chk(fault_addr == 0, "R1", fault_addr, 0);
    lpid_reg = 12'hA5C; pid_reg = 20'h1B2C3; offset_reg = 64'h0000_0040_0000_0000;
    // R3/R4 hv relocated quadrants
    step(1, 64'h0000_0000_1234_5678, 2'b00, 1, 1);
    step(1, 64'h4000_0000_1234_5678, 2'b01, 1, 1);
    step(1, 64'h8000_0000_1234_5678, 2'b10, 1, 1);
    step(1, 64'hC000_0000_1234_5678, 2'b00, 1, 1);
    // R5 guest legal quadrants
    step(1, 64'h0000_0000_0000_1000, 2'b00, 0, 1);
    step(1, 64'hC000_0000_0000_2000, 2'b10, 0, 1);
    // R6/R7 data fault, then fetch fault keeps address, context held
    step(1, 64'h4123_4567_89AB_CDE0, 2'b01, 0, 1);
    step(1, 64'h8FFF_0000_0000_0008, 2'b10, 0, 1);
    step(1, 64'h8000_0000_0000_0ABC, 2'b11, 0, 1);
    step(0, 0, 0, 0, 0);
    // R8/R9 real mode
    step(1, 64'hF123_4567_89AB_CDEF, 2'b00, 1, 0);
    step(1, 64'h7123_4567_89AB_CDEF, 2'b10, 1, 0);
    // R10 guest with relocation off
    step(1, 64'h0000_0000_0000_0040, 2'b00, 0, 0);
    step(1, 64'h4000_0000_0000_0040, 2'b00, 0, 0);
    step(1, 64'hC000_0000_0000_0040, 2'b01, 0, 0);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      lpid_reg = LW'($urandom); pid_reg = PW'($urandom);
      offset_reg = {$urandom, $urandom};
      step(($urandom % 4) != 0, {$urandom, $urandom}, 2'($urandom), 1'($urandom), 1'($urandom));
    end
    step(0, 0, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule